// File: doc/BRIEF.md
# Memory Channel Event Counter Unit

This block counts activity on one memory controller channel for performance analysis. It has eight counters, each 32 bits wide, and each counter is tied permanently to one event pulse input. The eight events are:

- write data beats and read data beats;
- write commands and read commands;
- precharge and activate commands;
- bank switches and rank switches.

Counter n always counts event input n. No event-select field exists.

Software reaches the unit through a simple word-addressed register bus. A write is a one-cycle strobe, and read data is returned combinationally for the address presented. Through this bus software can:

- set one global run bit;
- set a per-counter gate mask;
- load any counter and read it back;
- handle overflow through a mask register, a sticky status register and a write-one-to-clear acknowledge register.

A single level-sensitive interrupt output is high while any unmasked status flag is set.

A counter advances only when three things are true: its event pulse is high, the run bit is set, and its own gate bit is set. A counter that wraps from its all-ones value back to zero sets its status flag and keeps counting.

Top module: `mc_evcnt_unit`

## Requirements
- R1: After a synchronous reset the unit reads back as follows: run bit 0, gate mask 0x00, interrupt mask 0xFF, status 0x00, every counter 0, and the interrupt output low.
- R2: While the run bit (bit 1 of the control word at 0x010) is 1 and gate bit n (register 0x6C0) is 1, counter n adds exactly one on each clock edge at which event input n is high.
- R3: While the run bit is 0, no counter changes on event pulses, whatever the gate mask holds.
- R4: While gate bit n is 0, counter n does not change on event pulses, even when the run bit is 1.
- R5: Counter n is read and written at word address 0x380 + 0x40*(n/4) + 4*(n%4). A bus write to a counter in the same cycle as its event pulse loads the written value, and the increment is lost.
- R6: An increment from 0xFFFFFFFF leaves the counter at 0 and sets status bit n (register 0x6CC) on the same edge. Counting then continues from 0.
- R7: The interrupt output equals the OR over n of (status bit n AND NOT mask bit n), where the mask register is at 0x6C8 and a mask bit of 1 suppresses its flag.
- R8: Writing 1 to bit n of the acknowledge register (0x6D0) clears status bit n. Bits written as 0 leave their flags unchanged, and bus writes to the status register are ignored.
- R9: When a wrap and an acknowledge hit the same status bit in the same cycle, the bit ends set.
- R10: Several status bits can be set by wraps in the same cycle, and all of them are recorded.
- R11: The control word reads back only its run bit at bit 1, with all other bits 0. The acknowledge register and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | NUM_CNT | One pulse line per counter, counted once per high clock |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 12 | Byte address of the word being read or written |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Combinational read data for reg_addr |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
Some behaviours are checked by assertions on every cycle:

- each counter moves by at most one per cycle, and not at all when ungated;
- a counter write always wins over an increment;
- a wrap leaves the counter at zero;
- a wrap always leaves its status bit set, even against an acknowledge;
- unacknowledged flags stay set, and acknowledged ones clear;
- a fully masked unit keeps its interrupt low;
- reset leaves the specified register values.

Other behaviours only the bench scenarios can show. These are the exact counts accumulated under mixed run, gate and pulse patterns, the address map seen from the bus, and read-back of unused control bits. They also include the interrupt rising and falling as masks and acknowledges change, and several flags set together.

// File: rtl/mcec_pkg.sv
// Package: shared constants and address helpers for the event counter unit.
// Assumes a 12-bit byte address space with word-aligned registers.
package mcec_pkg;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned RUN_BIT = 1;

    localparam logic [ADDR_W-1:0] OFF_RUN  = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_GATE = 12'h6C0;
    localparam logic [ADDR_W-1:0] OFF_MASK = 12'h6C8;
    localparam logic [ADDR_W-1:0] OFF_FLAG = 12'h6CC;
    localparam logic [ADDR_W-1:0] OFF_ACK  = 12'h6D0;

    // Counters sit in groups of four words; each group starts 0x40 above the last.
    function automatic logic [ADDR_W-1:0] cnt_offset(input int unsigned idx);
        int unsigned a;
        a = 32'h380 + (idx / 4) * 32'h40 + (idx % 4) * 4;
        return a[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/mcec_counter.sv
// Module: one fixed-purpose event counter.
// Adds one per clock while its pulse is high and counting is allowed. A bus
// load replaces the value and wins over an increment. A wrap from all-ones
// to zero raises the wrap output for that cycle, so status and counter
// change on the same edge. Assumes synchronous active-low reset.
module mcec_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_ok,
    input  logic         evt,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic step;

    // Purpose: decide whether this cycle is a counted event.
    always_comb step = count_ok & evt & ~load;

    // Purpose: flag the all-ones to zero transition.
    always_comb wrap = step & (&value);

    // Purpose: hold, load or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n)      value <= '0;
        else if (load)   value <= load_val;
        else if (step)   value <= value + W'(1);
    end

    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (value == $past(value) || value == $past(value) + W'(1)));

    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_ok && !load) |=> $stable(value));

    p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> value == $past(load_val));

    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> value == '0);
endmodule

// File: rtl/mcec_regs.sv
// Module: register decode, control storage and read multiplexer.
// Holds the run bit, gate mask and interrupt mask. Produces one-hot counter
// load strobes and the acknowledge vector from bus writes, and returns read
// data combinationally for the presented address. Status is owned elsewhere
// and is only read here. Assumes word-aligned, exact-match addressing.
module mcec_regs
    import mcec_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [N-1:0]         bus_wbits,
    input  logic [N-1:0][DW-1:0] cnt_vals,
    input  logic [N-1:0]         status,
    output logic                 run_en,
    output logic [N-1:0]         gate,
    output logic [N-1:0]         mask,
    output logic [N-1:0]         load_vec,
    output logic [N-1:0]         ack_vec,
    output logic [DW-1:0]        rdata
);
    logic [N-1:0] hit;

    // Purpose: match the address against each counter slot.
    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = (bus_addr == cnt_offset(i));
    end

    // Purpose: bus write strobes toward counters and status.
    always_comb begin
        load_vec = hit & {N{bus_we}};
        ack_vec  = bus_wbits & {N{bus_we && (bus_addr == OFF_ACK)}};
    end

    // Purpose: store run bit, gate mask and interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en <= 1'b0;
            gate   <= '0;
            mask   <= '1;
        end else if (bus_we) begin
            if (bus_addr == OFF_RUN)  run_en <= bus_wbits[RUN_BIT];
            if (bus_addr == OFF_GATE) gate   <= bus_wbits;
            if (bus_addr == OFF_MASK) mask   <= bus_wbits;
        end
    end

    // Purpose: combinational read multiplexer.
    always_comb begin
        rdata = '0;
        if (bus_addr == OFF_RUN)  rdata[RUN_BIT] = run_en;
        if (bus_addr == OFF_GATE) rdata[N-1:0]   = gate;
        if (bus_addr == OFF_MASK) rdata[N-1:0]   = mask;
        if (bus_addr == OFF_FLAG) rdata[N-1:0]   = status;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) rdata = cnt_vals[i];
        end
    end

    p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ((&mask) && !run_en && gate == '0));

    p_run_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_RUN) |=> run_en == $past(bus_wbits[RUN_BIT]));
endmodule

// File: rtl/mcec_ovf.sv
// Module: overflow status flags and interrupt level.
// Each flag is set by its counter's wrap and cleared by a one in the
// acknowledge vector. A wrap wins over a clear in the same cycle. The
// interrupt output is the OR of unmasked flags. Assumes sync active-low reset.
module mcec_ovf #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wrap_vec,
    input  logic [N-1:0] ack_vec,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    // Purpose: sticky flags with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~ack_vec) | wrap_vec;
    end

    // Purpose: level interrupt from unmasked flags.
    always_comb irq = |(status & ~mask);

    p_wrap_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_vec) |=> (status & $past(wrap_vec)) == $past(wrap_vec));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_vec & ~wrap_vec)) |=> (status & $past(ack_vec & ~wrap_vec)) == '0);

    p_unacked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(status & ~ack_vec) & ~status) == '0);

    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);
endmodule

// File: rtl/mc_evcnt_unit.sv
// Module: top of the memory channel event counter unit.
// Eight (NUM_CNT) fixed-purpose counters, one per event pulse line, gated by
// a global run bit and a per-counter gate mask, with overflow flags and a
// level interrupt. Assumes NUM_CNT <= CNT_W and synchronous active-low reset.
module mc_evcnt_unit
    import mcec_pkg::*;
#(
    parameter int unsigned NUM_CNT = 8,
    parameter int unsigned CNT_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CNT-1:0]  evt_pulse,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [CNT_W-1:0]    reg_wdata,
    output logic [CNT_W-1:0]    reg_rdata,
    output logic                irq_o
);
    logic                          run_en;
    logic [NUM_CNT-1:0]            gate, mask, load_vec, ack_vec, wrap_vec, status;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vals;

    mcec_regs #(.N(NUM_CNT), .DW(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(reg_we), .bus_addr(reg_addr), .bus_wbits(reg_wdata[NUM_CNT-1:0]),
        .cnt_vals(cnt_vals), .status(status),
        .run_en(run_en), .gate(gate), .mask(mask),
        .load_vec(load_vec), .ack_vec(ack_vec), .rdata(reg_rdata)
    );

    // Purpose: one counter per event line, each with its own gate.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        mcec_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .count_ok(run_en & gate[i]), .evt(evt_pulse[i]),
            .load(load_vec[i]), .load_val(reg_wdata),
            .value(cnt_vals[i]), .wrap(wrap_vec[i])
        );
    end

    mcec_ovf #(.N(NUM_CNT)) u_ovf (
        .clk(clk), .rst_n(rst_n),
        .wrap_vec(wrap_vec), .ack_vec(ack_vec), .mask(mask),
        .status(status), .irq(irq_o)
    );

    p_run_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && load_vec == '0) |=> $stable(cnt_vals));
endmodule

// File: tb/sim_mc_evcnt_unit.sv
// Bench: table-driven counting checks, then directed reset and corner tests.
module sim_mc_evcnt_unit;
    import mcec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt = '0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] mdl [8];
    logic [31:0] got;

    always #4 clk = ~clk;

    mc_evcnt_unit u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt), .reg_we(we),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
    );

    // Fields: {run, gate[7:0], pulses[7:0], cycles[7:0]}
    localparam logic [24:0] VEC [0:7] = '{
        {1'b1, 8'hFF, 8'hFF, 8'd5},
        {1'b0, 8'hFF, 8'hFF, 8'd4},
        {1'b1, 8'h0F, 8'hFF, 8'd3},
        {1'b1, 8'hFF, 8'hA5, 8'd7},
        {1'b1, 8'h3C, 8'h0F, 8'd2},
        {1'b0, 8'h00, 8'hFF, 8'd2},
        {1'b1, 8'h81, 8'hC3, 8'd9},
        {1'b1, 8'hFF, 8'h00, 8'd6}
    };

    task automatic chk(input string tag, input logic [31:0] g, input logic [31:0] e);
        n_chk++;
        if (g !== e) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, g, e);
        end
    endtask

    // One clock: drive at negedge, pass one posedge, release at next negedge.
    task automatic cyc(input logic w, input logic [11:0] a, input logic [31:0] d, input logic [7:0] e);
        we = w; addr = a; wdata = d; evt = e;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; evt = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(OFF_RUN, got);  chk("R1 run", got, 32'h0);
        rd(OFF_GATE, got); chk("R1 gate", got, 32'h0);
        rd(OFF_MASK, got); chk("R1 mask", got, 32'hFF);
        rd(OFF_FLAG, got); chk("R1 status", got, 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd(cnt_offset(i), got); chk("R1 counter", got, 32'h0);
            mdl[i] = '0;
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 R3 R4: table of run/gate/pulse patterns
        for (int v = 0; v < 8; v++) begin
            logic       run;
            logic [7:0] gt, ev, nc;
            {run, gt, ev, nc} = VEC[v];
            cyc(1'b1, OFF_RUN, run ? 32'h2 : 32'h0, 8'h00);
            cyc(1'b1, OFF_GATE, {24'h0, gt}, 8'h00);
            for (int k = 0; k < int'(nc); k++) cyc(1'b0, 12'h000, 32'h0, ev);
            for (int i = 0; i < 8; i++) begin
                if (run && gt[i] && ev[i]) mdl[i] = mdl[i] + 32'(nc);
                rd(cnt_offset(i), got);
                chk("R2 R3 R4 table count", got, mdl[i]);
            end
        end

        // R5: load/readback and write priority over increment
        cyc(1'b1, OFF_RUN, 32'h2, 8'h00);
        cyc(1'b1, OFF_GATE, 32'hFF, 8'h00);
        cyc(1'b1, cnt_offset(3), 32'h12345678, 8'h00);
        rd(12'h38C, got); chk("R5 load readback", got, 32'h12345678);
        cyc(1'b1, cnt_offset(6), 32'hCAFE0000, 8'h40);
        rd(12'h3C8, got); chk("R5 write wins", got, 32'hCAFE0000);
        cyc(1'b0, 12'h000, 32'h0, 8'h40);
        rd(12'h3C8, got); chk("R5 counts after load", got, 32'hCAFE0001);

        // R6: wrap behaviour on counter 0
        cyc(1'b1, cnt_offset(0), 32'hFFFFFFFE, 8'h00);
        cyc(1'b0, 12'h000, 32'h0, 8'h01);
        rd(OFF_FLAG, got); chk("R6 no flag before wrap", got, 32'h0);
        cyc(1'b0, 12'h000, 32'h0, 8'h01);
        rd(cnt_offset(0), got); chk("R6 wraps to zero", got, 32'h0);
        rd(OFF_FLAG, got); chk("R6 flag on wrap", got, 32'h1);
        repeat (3) cyc(1'b0, 12'h000, 32'h0, 8'h01);
        rd(cnt_offset(0), got); chk("R6 keeps counting", got, 32'h3);

        // R7: interrupt follows mask
        chk("R7 irq masked", {31'b0, irq}, 32'h0);
        cyc(1'b1, OFF_MASK, 32'hFE, 8'h00);
        chk("R7 irq unmasked", {31'b0, irq}, 32'h1);
        cyc(1'b1, OFF_MASK, 32'hFF, 8'h00);
        chk("R7 irq remasked", {31'b0, irq}, 32'h0);
        cyc(1'b1, OFF_MASK, 32'h00, 8'h00);

        // R8: acknowledge semantics
        cyc(1'b1, OFF_ACK, 32'h0, 8'h00);
        rd(OFF_FLAG, got); chk("R8 zero ack no effect", got, 32'h1);
        cyc(1'b1, OFF_FLAG, 32'h0, 8'h00);
        rd(OFF_FLAG, got); chk("R8 status write ignored", got, 32'h1);
        cyc(1'b1, OFF_ACK, 32'h1, 8'h00);
        rd(OFF_FLAG, got); chk("R8 ack clears", got, 32'h0);
        chk("R8 irq drops", {31'b0, irq}, 32'h0);

        // R9: wrap and ack together on bit 1
        cyc(1'b1, cnt_offset(1), 32'hFFFFFFFF, 8'h00);
        cyc(1'b0, 12'h000, 32'h0, 8'h02);
        rd(OFF_FLAG, got); chk("R9 setup flag", got, 32'h2);
        cyc(1'b1, cnt_offset(1), 32'hFFFFFFFF, 8'h00);
        cyc(1'b1, OFF_ACK, 32'h2, 8'h02);
        rd(OFF_FLAG, got); chk("R9 wrap beats ack", got, 32'h2);
        cyc(1'b1, OFF_ACK, 32'hFF, 8'h00);

        // R10: two wraps at once
        cyc(1'b1, cnt_offset(2), 32'hFFFFFFFF, 8'h00);
        cyc(1'b1, cnt_offset(5), 32'hFFFFFFFF, 8'h00);
        cyc(1'b0, 12'h000, 32'h0, 8'h24);
        rd(OFF_FLAG, got); chk("R10 two flags", got, 32'h24);
        chk("R10 irq", {31'b0, irq}, 32'h1);

        // R11: control read-back and unmapped space
        cyc(1'b1, OFF_RUN, 32'hFFFFFFFF, 8'h00);
        rd(OFF_RUN, got); chk("R11 run readback", got, 32'h2);
        rd(OFF_ACK, got); chk("R11 ack reads zero", got, 32'h0);
        rd(12'h100, got); chk("R11 unmapped", got, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule